// File: doc/BRIEF.md
# Serial Link Downstream Frame Receiver

This block sits on the codec side of a fixed-rate 48 kHz time-division serial link. It watches the bit clock, the frame-sync line and the downstream data line. Each time a frame begins it collects the 256 bits, then hands two things to the rest of the codec: any register command the controller placed in the frame, and one stereo pair of playback samples.

The link carries several codecs. A 2-bit identity, taken from strapping pins, selects which data slots hold this codec's left and right audio. The tag word at the head of the frame marks which slots carry data. A slot that is not tagged is treated as zero. A frame whose head bit is clear is dropped. A frame that is cut short by an early sync edge is also dropped, and counting starts again from the new edge.

The block runs on a fast system clock. The bit clock, sync and data inputs are sampled in that clock domain, and the falling edges of the bit clock are detected from the samples. The outputs stay at their last values between strobes.

Top module: `tdm_frame_rx`

## Requirements
- R1: Bits are sampled on the falling edges of the bit clock, first bit = most significant. A frame starts at the falling edge where sync is first seen high after being seen low. The first data bit is taken on the next falling edge.
- R2: A frame is 256 bits: a 16-bit tag word (slot 0), then slots 1 to 12 of 20 bits each. Outputs update only after the 256th bit. When frames are sent back to back with no gap, every one of them is decoded.
- R3: If tag bit 15 is 0, the frame produces no strobe and all outputs keep their previous values.
- R4: Tag bits 14 down to 3 mark slots 1 to 12 as valid: bit 14 is slot 1 and bit 3 is slot 12. If the slot 1 tag is clear, no command is issued.
- R5: Slot 1 bit 19 is the read flag (1 = read, 0 = write). Slot 1 bits 18:12 are the 7-bit register index, and bits 11:0 are ignored. On a write, the 16-bit write data is slot 2 bits 19:4. On a read, the write data output is zero.
- R6: The command strobe fires only when tag bit 15 and the slot 1 tag are both set and, for a write, the slot 2 tag is also set.
- R7: The playback slots depend on the codec identity. Identity 00 and 01 use slots 3 (left) and 4 (right). Identity 10 uses slots 7 and 8. Identity 11 uses slots 6 and 9.
- R8: A playback sample is the 18-bit two's-complement value in slot bits 19:2. If that slot's tag bit is clear, the sample is zero.
- R9: If sync rises again before all 256 bits of a frame have arrived, the partial frame produces nothing and bit counting restarts from the new edge.
- R10: Each decoded valid frame gives exactly one sample strobe, one system clock wide. Each frame gives at most one command strobe.
- R11: After synchronous reset, all strobes are low and all sample, index and data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all link inputs are sampled on it |
| rst | input | 1 | Synchronous active-high reset |
| bit_clk | input | 1 | Serial link bit clock, synchronous to clk |
| sync_in | input | 1 | Frame sync line |
| sdata_in | input | 1 | Downstream serial data, controller to codec |
| codec_id | input | 2 | Strapped codec identity, selects the playback slots |
| cmd_valid | output | 1 | One-cycle strobe: a qualified register command was received |
| cmd_read | output | 1 | 1 = read command, 0 = write command |
| cmd_index | output | 7 | Register index of the command |
| cmd_wdata | output | 16 | Write data; zero for a read |
| pcm_valid | output | 1 | One-cycle strobe: a valid frame delivered a sample pair |
| pcm_left | output | 18 | Left playback sample, two's complement |
| pcm_right | output | 18 | Right playback sample, two's complement |

## Verification
Two situations are hard to reach from the ports: a sync edge that arrives partway through a frame, and a sync edge that falls on the same bit-clock falling edge as the last data bit of the previous frame. The bench reaches the first by sending the head of one frame, stopping early, and then starting a complete frame. Only the second frame's values may come out. The bench reaches the second by streaming frames with no gap, so that each frame's final bit travels in the same bit period as the next frame's sync edge. Random frames with random identities and tag words then cover the mix of slot selection, zeroed slots and command qualification.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;

    localparam int TAG_BITS   = 16;
    localparam int SLOT_BITS  = 20;
    localparam int LAST_SLOT  = 12;
    localparam int SAMPLE_W   = 18;
    localparam int INDEX_W    = 7;
    localparam int REG_W      = 16;
    localparam int ID_W       = 2;
    localparam int FRAME_BITS = TAG_BITS + LAST_SLOT * SLOT_BITS;
    localparam int SLOT_IDX_W = $clog2(LAST_SLOT + 1);
    localparam int BIT_IDX_W  = $clog2(SLOT_BITS);
    localparam int FCNT_W     = $clog2(FRAME_BITS) + 1;

    typedef logic [SLOT_IDX_W-1:0] slot_idx_t;

    typedef enum logic [ID_W-1:0] {
        ID_PRIMARY = 2'b00,
        ID_SEC_LOW = 2'b01,
        ID_SEC_MID = 2'b10,
        ID_SEC_TOP = 2'b11
    } codec_id_e;

    typedef struct packed {
        logic               rd;
        logic [INDEX_W-1:0] index;
        logic [REG_W-1:0]   wdata;
    } reg_cmd_t;

    typedef struct packed {
        logic [SAMPLE_W-1:0] left;
        logic [SAMPLE_W-1:0] right;
    } pcm_pair_t;

    function automatic slot_idx_t left_slot(input logic [ID_W-1:0] id);
        case (codec_id_e'(id))
            ID_SEC_TOP: return slot_idx_t'(6);
            ID_SEC_MID: return slot_idx_t'(7);
            default:    return slot_idx_t'(3);
        endcase
    endfunction

    function automatic slot_idx_t right_slot(input logic [ID_W-1:0] id);
        case (codec_id_e'(id))
            ID_SEC_TOP: return slot_idx_t'(9);
            ID_SEC_MID: return slot_idx_t'(8);
            default:    return slot_idx_t'(4);
        endcase
    endfunction

    // Valid tag of slot s sits at tag bit (TAG_BITS-1-s).
    function automatic logic slot_tag(input logic [TAG_BITS-1:0] tag, input slot_idx_t s);
        logic [3:0] pos;
        pos = 4'(TAG_BITS - 1) - 4'(s);
        return tag[pos];
    endfunction

endpackage

// File: rtl/tdm_rx_sampler.sv
module tdm_rx_sampler
    import tdm_rx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_clk,
    input  logic sync_in,
    input  logic sdata_in,
    output logic bit_stb,
    output logic sync_bit,
    output logic data_bit
);

    logic bclk_q;
    logic bclk_qq;

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_q   <= 1'b0;
            bclk_qq  <= 1'b0;
            sync_bit <= 1'b0;
            data_bit <= 1'b0;
        end else begin
            bclk_q   <= bit_clk;
            bclk_qq  <= bclk_q;
            sync_bit <= sync_in;
            data_bit <= sdata_in;
        end
    end

    // Falling edge of the bit clock, seen one system cycle late.
    assign bit_stb = bclk_qq & ~bclk_q;

    assert_fall_seen_R1: assert property (@(posedge clk) disable iff (rst)
        bit_stb |-> ($past(bit_clk, 2) && !$past(bit_clk)));

endmodule

// File: rtl/tdm_rx_framer.sv
module tdm_rx_framer
    import tdm_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      bit_stb,
    input  logic      sync_bit,
    output logic      take_bit,
    output logic      slot_end,
    output logic      frame_end,
    output logic      restart,
    output slot_idx_t slot
);

    logic                 active;
    logic                 sync_prev;
    logic [BIT_IDX_W-1:0] bitcnt;
    logic                 slot_last;
    logic [FCNT_W-1:0]    seen_bits;

    assign slot_last = (slot == '0) ? (bitcnt == BIT_IDX_W'(TAG_BITS - 1))
                                    : (bitcnt == BIT_IDX_W'(SLOT_BITS - 1));
    assign take_bit  = bit_stb & active;
    assign slot_end  = take_bit & slot_last;
    assign frame_end = slot_end & (slot == slot_idx_t'(LAST_SLOT));
    assign restart   = bit_stb & sync_bit & ~sync_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= 1'b0;
            sync_prev <= 1'b0;
            bitcnt    <= '0;
            slot      <= '0;
        end else if (bit_stb) begin
            sync_prev <= sync_bit;
            if (restart) begin
                active <= 1'b1;
                slot   <= '0;
                bitcnt <= '0;
            end else if (active) begin
                if (slot_last) begin
                    bitcnt <= '0;
                    if (slot == slot_idx_t'(LAST_SLOT)) begin
                        active <= 1'b0;
                        slot   <= '0;
                    end else begin
                        slot <= slot + slot_idx_t'(1);
                    end
                end else begin
                    bitcnt <= bitcnt + BIT_IDX_W'(1);
                end
            end
        end
    end

    // Separate running count of accepted bits since the last frame start.
    always_ff @(posedge clk) begin
        if (rst) begin
            seen_bits <= '0;
        end else if (restart) begin
            seen_bits <= '0;
        end else if (take_bit) begin
            seen_bits <= seen_bits + FCNT_W'(1);
        end
    end

    assert_frame_len_R2: assert property (@(posedge clk) disable iff (rst)
        frame_end |-> (seen_bits == FCNT_W'(FRAME_BITS - 1)));

    assert_restart_R9: assert property (@(posedge clk) disable iff (rst)
        restart |=> (active && slot == '0 && bitcnt == '0));

endmodule

// File: rtl/tdm_rx_decoder.sv
module tdm_rx_decoder
    import tdm_rx_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            take_bit,
    input  logic            data_bit,
    input  logic            slot_end,
    input  logic            frame_end,
    input  slot_idx_t       slot,
    input  logic [ID_W-1:0] codec_id,
    output logic            cmd_valid,
    output reg_cmd_t        cmd,
    output logic            pcm_valid,
    output pcm_pair_t       pcm
);

    logic [SLOT_BITS-2:0] shreg;
    logic [SLOT_BITS-1:0] word;
    logic [TAG_BITS-1:0]  tag_q;
    logic                 rd_q;
    logic [INDEX_W-1:0]   idx_q;
    logic [REG_W-1:0]     wdat_q;
    logic [SAMPLE_W-1:0]  left_q;
    logic [SAMPLE_W-1:0]  right_q;
    slot_idx_t            ls;
    slot_idx_t            rs;
    logic                 cmd_ok;

    assign word   = {shreg, data_bit};
    assign ls     = left_slot(codec_id);
    assign rs     = right_slot(codec_id);
    assign cmd_ok = slot_tag(tag_q, slot_idx_t'(1)) &
                    (rd_q | slot_tag(tag_q, slot_idx_t'(2)));

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
        end else if (take_bit) begin
            shreg <= word[SLOT_BITS-2:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q   <= '0;
            rd_q    <= 1'b0;
            idx_q   <= '0;
            wdat_q  <= '0;
            left_q  <= '0;
            right_q <= '0;
        end else if (slot_end) begin
            if (slot == slot_idx_t'(0)) tag_q <= word[TAG_BITS-1:0];
            if (slot == slot_idx_t'(1)) begin
                rd_q  <= word[SLOT_BITS-1];
                idx_q <= word[SLOT_BITS-2 -: INDEX_W];
            end
            if (slot == slot_idx_t'(2)) wdat_q  <= word[SLOT_BITS-1 -: REG_W];
            if (slot == ls)             left_q  <= word[SLOT_BITS-1 -: SAMPLE_W];
            if (slot == rs)             right_q <= word[SLOT_BITS-1 -: SAMPLE_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_valid <= 1'b0;
            pcm_valid <= 1'b0;
            cmd       <= '0;
            pcm       <= '0;
        end else begin
            cmd_valid <= 1'b0;
            pcm_valid <= 1'b0;
            if (frame_end && tag_q[TAG_BITS-1]) begin
                pcm_valid  <= 1'b1;
                pcm.left   <= slot_tag(tag_q, ls) ? left_q  : '0;
                pcm.right  <= slot_tag(tag_q, rs) ? right_q : '0;
                if (cmd_ok) begin
                    cmd_valid <= 1'b1;
                    cmd.rd    <= rd_q;
                    cmd.index <= idx_q;
                    cmd.wdata <= rd_q ? '0 : wdat_q;
                end
            end
        end
    end

    assert_hold_pcm_R3: assert property (@(posedge clk) disable iff (rst)
        !pcm_valid |-> $stable(pcm));

    assert_hold_cmd_R3: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |-> $stable(cmd));

    assert_read_nodata_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd.rd) |-> (cmd.wdata == '0));

    assert_cmd_in_frame_R6: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> pcm_valid);

    assert_untagged_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (pcm_valid && !slot_tag(tag_q, ls)) |-> (pcm.left == '0));

    assert_one_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        pcm_valid |=> !pcm_valid);

endmodule

// File: rtl/tdm_frame_rx.sv
module tdm_frame_rx
    import tdm_rx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                bit_clk,
    input  logic                sync_in,
    input  logic                sdata_in,
    input  logic [ID_W-1:0]     codec_id,
    output logic                cmd_valid,
    output logic                cmd_read,
    output logic [INDEX_W-1:0]  cmd_index,
    output logic [REG_W-1:0]    cmd_wdata,
    output logic                pcm_valid,
    output logic [SAMPLE_W-1:0] pcm_left,
    output logic [SAMPLE_W-1:0] pcm_right
);

    logic      bit_stb;
    logic      sync_bit;
    logic      data_bit;
    logic      take_bit;
    logic      slot_end;
    logic      frame_end;
    logic      restart;
    slot_idx_t slot;
    reg_cmd_t  cmd;
    pcm_pair_t pcm;

    tdm_rx_sampler u_sampler (
        .clk      (clk),
        .rst      (rst),
        .bit_clk  (bit_clk),
        .sync_in  (sync_in),
        .sdata_in (sdata_in),
        .bit_stb  (bit_stb),
        .sync_bit (sync_bit),
        .data_bit (data_bit)
    );

    tdm_rx_framer u_framer (
        .clk       (clk),
        .rst       (rst),
        .bit_stb   (bit_stb),
        .sync_bit  (sync_bit),
        .take_bit  (take_bit),
        .slot_end  (slot_end),
        .frame_end (frame_end),
        .restart   (restart),
        .slot      (slot)
    );

    tdm_rx_decoder u_decoder (
        .clk       (clk),
        .rst       (rst),
        .take_bit  (take_bit),
        .data_bit  (data_bit),
        .slot_end  (slot_end),
        .frame_end (frame_end),
        .slot      (slot),
        .codec_id  (codec_id),
        .cmd_valid (cmd_valid),
        .cmd       (cmd),
        .pcm_valid (pcm_valid),
        .pcm       (pcm)
    );

    assign cmd_read  = cmd.rd;
    assign cmd_index = cmd.index;
    assign cmd_wdata = cmd.wdata;
    assign pcm_left  = pcm.left;
    assign pcm_right = pcm.right;

endmodule

// File: tb/tdm_frame_rx_tb.sv
`timescale 1ns/1ps
module tdm_frame_rx_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_clk = 1'b0;
    logic        sync_in = 1'b0;
    logic        sdata_in = 1'b0;
    logic [1:0]  codec_id = 2'b00;
    logic        cmd_valid, cmd_read, pcm_valid;
    logic [6:0]  cmd_index;
    logic [15:0] cmd_wdata;
    logic [17:0] pcm_left, pcm_right;

    int total = 0;
    int fails = 0;
    int pcm_cnt = 0;
    int cmd_cnt = 0;
    bit done = 0;

    logic [15:0]  tg;
    logic [19:0]  sl [1:12];
    logic         carry = 1'b0;
    logic [17:0]  mdl_l = '0, mdl_r = '0;
    logic         mdl_rd = 1'b0;
    logic [6:0]   mdl_idx = '0;
    logic [15:0]  mdl_wd = '0;

    always #2.5 clk = ~clk;

    tdm_frame_rx u_dut (
        .clk(clk), .rst(rst), .bit_clk(bit_clk), .sync_in(sync_in),
        .sdata_in(sdata_in), .codec_id(codec_id),
        .cmd_valid(cmd_valid), .cmd_read(cmd_read), .cmd_index(cmd_index),
        .cmd_wdata(cmd_wdata), .pcm_valid(pcm_valid),
        .pcm_left(pcm_left), .pcm_right(pcm_right)
    );

    always @(negedge clk) begin
        if (!rst && pcm_valid) pcm_cnt++;
        if (!rst && cmd_valid) cmd_cnt++;
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int lslot(input logic [1:0] id);
        if (id == 2'b11) return 6;
        if (id == 2'b10) return 7;
        return 3;
    endfunction

    function automatic int rslot(input logic [1:0] id);
        if (id == 2'b11) return 9;
        if (id == 2'b10) return 8;
        return 4;
    endfunction

    function automatic logic [255:0] pack_frame();
        logic [255:0] f;
        f = '0;
        f[255 -: 16] = tg;
        for (int k = 1; k <= 12; k++) f[239 - 20*(k-1) -: 20] = sl[k];
        return f;
    endfunction

    task automatic fill_slots(input logic [19:0] base);
        for (int k = 1; k <= 12; k++) sl[k] = base ^ (20'h0B3C7 * k) ^ (20'h40000 >> k);
    endtask

    // One bit-clock period: drive on the high phase, sampled at its fall.
    task automatic tick(input logic s, input logic d);
        bit_clk  = 1'b1;
        sync_in  = s;
        sdata_in = d;
        repeat (2) @(negedge clk);
        bit_clk = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // The sync tick carries the last bit of the previous frame.
    task automatic send_frame(input logic [255:0] f);
        tick(1'b1, carry);
        for (int i = 0; i < 255; i++) tick(i < 15, f[255-i]);
        carry = f[0];
    endtask

    task automatic send_partial(input logic [255:0] f, input int n);
        tick(1'b1, carry);
        for (int i = 0; i < n - 1; i++) tick(i < 15, f[255-i]);
        carry = 1'b0;
    endtask

    task automatic flush();
        tick(1'b0, carry);
        carry = 1'b0;
        tick(1'b0, 1'b0);
        tick(1'b0, 1'b0);
    endtask

    // Update the bench model from the current frame fields; return strobe expectations.
    task automatic model_frame(input logic [1:0] id, output bit ep, output bit ec);
        int ls, rs;
        ls = lslot(id);
        rs = rslot(id);
        ep = tg[15];
        ec = tg[15] && tg[14] && (sl[1][19] || tg[13]);
        if (ep) begin
            mdl_l = tg[15-ls] ? sl[ls][19:2] : 18'h0;
            mdl_r = tg[15-rs] ? sl[rs][19:2] : 18'h0;
        end
        if (ec) begin
            mdl_rd  = sl[1][19];
            mdl_idx = sl[1][18:12];
            mdl_wd  = sl[1][19] ? 16'h0 : sl[2][19:4];
        end
    endtask

    task automatic check_outputs(input string tag);
        chk("R7", {tag, " left"},  pcm_left,  mdl_l);
        chk("R7", {tag, " right"}, pcm_right, mdl_r);
        chk("R5", {tag, " read flag"}, cmd_read, mdl_rd);
        chk("R5", {tag, " index"}, cmd_index, mdl_idx);
        chk("R5", {tag, " wdata"}, cmd_wdata, mdl_wd);
    endtask

    task automatic run_case(input logic [1:0] id, input string tag);
        int p0, c0;
        bit ep, ec;
        codec_id = id;
        p0 = pcm_cnt;
        c0 = cmd_cnt;
        send_frame(pack_frame());
        flush();
        model_frame(id, ep, ec);
        chk(ep ? "R10" : "R3", {tag, " sample strobes"}, pcm_cnt - p0, ep ? 1 : 0);
        chk("R6", {tag, " command strobes"}, cmd_cnt - c0, ec ? 1 : 0);
        check_outputs(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL R2 watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", total, fails);
            $finish;
        end
    end

    initial begin
        logic [255:0] fa;
        int p0, c0;
        void'($urandom(32'd20240611));
        repeat (6) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R11: reset state
        chk("R11", "pcm_valid", pcm_valid, 0);
        chk("R11", "cmd_valid", cmd_valid, 0);
        chk("R11", "left",  pcm_left, 0);
        chk("R11", "right", pcm_right, 0);
        chk("R11", "index", cmd_index, 0);
        chk("R11", "wdata", cmd_wdata, 0);

        // R1 R2 R7: all tags set, write command, each identity
        tg = 16'hFFF8;
        fill_slots(20'h5A3C1);
        sl[1] = {1'b0, 7'h26, 12'hABC};
        sl[2] = {16'hA5C3, 4'hF};
        run_case(2'b00, "R1 id00");
        fill_slots(20'h1E2D3);
        sl[1] = {1'b0, 7'h13, 12'h000};
        sl[2] = {16'h3C5A, 4'h0};
        run_case(2'b01, "R7 id01");
        fill_slots(20'h7F0E1);
        sl[1] = {1'b0, 7'h55, 12'h000};
        run_case(2'b10, "R7 id10");
        fill_slots(20'h29B4E);
        sl[1] = {1'b0, 7'h2A, 12'h000};
        run_case(2'b11, "R7 id11");

        // R8: left slot untagged reads as zero
        tg = 16'hEFF8;
        fill_slots(20'hC0FFE);
        run_case(2'b00, "R8 untagged left");

        // R3: frame-valid bit clear, everything else set
        tg = 16'h7FF8;
        fill_slots(20'h31337);
        sl[1] = {1'b0, 7'h01, 12'h000};
        run_case(2'b00, "R3 invalid frame");

        // R6: write without slot 2 tag
        tg = 16'hDFF8;
        fill_slots(20'h4D2F1);
        sl[1] = {1'b0, 7'h3E, 12'h000};
        run_case(2'b00, "R6 write no data tag");

        // R5: read without slot 2 tag still issues, data zero
        sl[1] = {1'b1, 7'h7C, 12'h000};
        sl[2] = {16'hFFFF, 4'h0};
        run_case(2'b00, "R5 read");

        // R4: slot 1 tag clear suppresses command
        tg = 16'hBFF8;
        fill_slots(20'h0A0A5);
        sl[1] = {1'b0, 7'h11, 12'h000};
        run_case(2'b10, "R4 no command tag");

        // R9: truncated frame followed by a full one
        tg = 16'hFFF8;
        fill_slots(20'h77777);
        sl[1] = {1'b0, 7'h6B, 12'h000};
        codec_id = 2'b00;
        fa = pack_frame();
        p0 = pcm_cnt;
        send_partial(fa, 120);
        chk("R9", "no strobe from partial", pcm_cnt - p0, 0);
        fill_slots(20'h2468A);
        sl[1] = {1'b0, 7'h19, 12'h000};
        run_case(2'b00, "R9 after restart");

        // R2: back-to-back frames, last bit shares the next sync tick
        codec_id = 2'b11;
        p0 = pcm_cnt;
        c0 = cmd_cnt;
        fill_slots(20'h13579);
        sl[1] = {1'b0, 7'h22, 12'h000};
        send_frame(pack_frame());
        fill_slots(20'h9ABCD);
        sl[1] = {1'b0, 7'h44, 12'h000};
        send_frame(pack_frame());
        flush();
        begin
            bit ep, ec;
            model_frame(2'b11, ep, ec);
        end
        chk("R2", "back-to-back sample strobes", pcm_cnt - p0, 2);
        chk("R2", "back-to-back command strobes", cmd_cnt - c0, 2);
        check_outputs("R2 back-to-back");

        // Random frames
        for (int n = 0; n < 24; n++) begin
            logic [1:0] id;
            id = 2'($urandom);
            tg = 16'($urandom);
            tg[15] = ($urandom % 5) != 0;
            for (int k = 1; k <= 12; k++) sl[k] = 20'($urandom);
            run_case(id, "R7 random");
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", total, fails);
        $finish;
    end

endmodule